// File: doc/BRIEF.md
# Per-Lane Receive Deskew Trainer

This block sits behind a multi-lane serial receiver. The receiver oversamples each data lane three times per bit. For every lane, the block chooses one of seven sampling phases, spaced one third of a bit apart and covering one bit either side of the nominal strobe. Each lane is calibrated on its own.

The block watches the recovered 7-bit word of the clock lane. Two particular clock-lane shapes mean that the transmitter is sending the training pattern. While training runs, the block compares each lane's candidate words with the expected training word. It keeps the phase at the centre of the matching run and holds all recovered data at zero. When the clock lane returns to its normal shape, data flows out through the locked phases.

With the deskew enable low, the block samples every lane at the nominal phase and never trains. A trained flag tells downstream logic when the recovered data can be trusted.

Top module: `deskew_trainer`

## Requirements
- R1: After reset, `phase_o`, `data_o` and `trained_o` are all zero.
- R2: With `deskew_en` high, a `clk_word` of 7'b1111100 or 7'b1100000 puts the block in training from that clock edge. From that same edge, `data_o` is all zero on every lane.
- R3: Training ends at the edge where `clk_word` is 7'b1111000 or 7'b1110000. Any other word leaves the mode unchanged.
- R4: For lane k, candidate phase p (-3..+3) forms a word whose bit 6-i is `lane_samp[k*27 + 4 + 3*i + p]`, where i = 0..6. On a training cycle, each lane independently takes the centre of the lowest-indexed contiguous run of phases whose word equals 7'b1111000. For an even-length run, the centre is rounded toward the lower phase.
- R5: On a training cycle where no phase of a lane matches, that lane keeps its previous phase.
- R6: A lane counts as locked once it has matched since training was last entered. Locks clear on the first training word, unless the lane matches on that word. `trained_o` is high exactly while every lane is locked.
- R7: With `deskew_en` low, training words are ignored. At the next edge, every phase is 0 and `trained_o` is low, and data is sampled at phase 0.
- R8: Outside training, `data_o` for each lane is, one edge later, the word sampled at that lane's current phase.
- R9: `phase_o[3k+2:3k]` is lane k's phase as a 3-bit two's-complement value, and never equals -4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| deskew_en | input | 1 | Enables training and per-lane phase selection |
| clk_word | input | 7 | Recovered clock-lane word |
| lane_samp | input | 108 | 27 oversampled samples per lane, lane 0 lowest |
| phase_o | output | 12 | Selected phase per lane, 3 bits each |
| data_o | output | 28 | Recovered 7-bit word per lane, lane 0 lowest |
| trained_o | output | 1 | All lanes locked since the last training entry |

## Verification
On the first training word, two things fall on the same edge: the old locks are cleared, and the new captures are taken. A directed retrain provokes this by giving some lanes a matching first training word and withholding it from one lane. It is judged by `trained_o` staying low while the matching lanes show their new phases and the missing lane keeps its old one. The exit edge also coincides with the first unmuted data. Random runs mix entry, exit and enable drops against a bench reference model.

// File: rtl/deskew_trainer.sv
module deskew_trainer #(
  parameter int LANES = 4,
  parameter int WORD = 7,
  parameter int OVS = 3,
  parameter logic [WORD-1:0] TRN_A = 7'b1111100,
  parameter logic [WORD-1:0] TRN_B = 7'b1100000,
  parameter logic [WORD-1:0] NRM_A = 7'b1111000,
  parameter logic [WORD-1:0] NRM_B = 7'b1110000,
  parameter logic [WORD-1:0] EXP_W = 7'b1111000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              deskew_en,
  input  logic [WORD-1:0]                   clk_word,
  input  logic [LANES*OVS*(WORD+2)-1:0]     lane_samp,
  output logic [LANES*($clog2(OVS+1)+1)-1:0] phase_o,
  output logic [LANES*WORD-1:0]             data_o,
  output logic                              trained_o
);
  localparam int NPH = 2*OVS + 1;
  localparam int SPAN = OVS*(WORD+2);
  localparam int PW = $clog2(OVS+1) + 1;

  function automatic logic [WORD-1:0] grab(input logic [SPAN-1:0] v, input int p);
    for (int i = 0; i < WORD; i++) grab[WORD-1-i] = v[OVS + OVS*i + OVS/2 + p];
  endfunction

  logic train_q;
  logic [LANES-1:0] locked;
  wire is_trn = (clk_word == TRN_A) || (clk_word == TRN_B);
  wire is_nrm = (clk_word == NRM_A) || (clk_word == NRM_B);
  wire train_nx = deskew_en && (is_trn || (train_q && !is_nrm));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) train_q <= 1'b0;
    else        train_q <= train_nx;

  assign trained_o = &locked;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire [SPAN-1:0] s = lane_samp[g*SPAN +: SPAN];
    logic [NPH-1:0] hit;
    logic [PW-1:0]  pick, ph;
    logic [WORD-1:0] dq;
    logic lk;

    always_comb begin
      int lo, hi;
      for (int k = 0; k < NPH; k++) hit[k] = (grab(s, k - OVS) == EXP_W);
      lo = -1;
      for (int k = 0; k < NPH; k++) if (hit[k] && lo < 0) lo = k;
      hi = lo;
      for (int k = 0; k < NPH; k++) if (lo >= 0 && k == hi + 1 && hit[k]) hi = k;
      pick = PW'((lo + hi)/2 - OVS);
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ph <= '0; lk <= 1'b0; dq <= '0;
      end else begin
        if (!deskew_en) begin
          ph <= '0; lk <= 1'b0;
        end else if (train_nx && |hit) begin
          ph <= pick; lk <= 1'b1;
        end else if (train_nx && !train_q) begin
          lk <= 1'b0;
        end
        dq <= train_nx ? '0 : grab(s, deskew_en ? int'($signed(ph)) : 0);
      end

    assign phase_o[g*PW +: PW] = ph;
    assign data_o[g*WORD +: WORD] = dq;
    assign locked[g] = lk;

    // R9
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(ph) >= -OVS) && ($signed(ph) <= OVS));
    // R7
    phase_nominal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !deskew_en |=> (ph == '0));
  end

  // R2
  mute_in_train_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_q |-> (data_o == '0));
  // R7
  no_train_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !deskew_en |=> (!train_q && !trained_o));
  // R6
  trained_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trained_o) |-> train_q);
endmodule

// File: tb/tb_deskew_trainer.sv
module tb_deskew_trainer;
  localparam int CLK_PER = 10;
  localparam int LANES = 4;
  localparam int SPAN = 27;
  localparam logic [6:0] EXPW = 7'b1111000;

  logic clk = 0, rst_n = 0, deskew_en = 0;
  logic [6:0] clk_word = 7'b1111000;
  logic [LANES*SPAN-1:0] lane_samp = '0;
  logic [LANES*3-1:0] phase_o;
  logic [LANES*7-1:0] data_o;
  logic trained_o;

  deskew_trainer dut (.clk(clk), .rst_n(rst_n), .deskew_en(deskew_en), .clk_word(clk_word),
    .lane_samp(lane_samp), .phase_o(phase_o), .data_o(data_o), .trained_o(trained_o));

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit m_train = 0;
  int m_ph[LANES];
  bit m_lk[LANES];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] grab(logic [SPAN-1:0] v, int p);
    for (int i = 0; i < 7; i++) grab[6-i] = v[4 + 3*i + p];
  endfunction

  // serial word delayed by s thirds of a bit, zeros outside the word
  function automatic logic [SPAN-1:0] mk(logic [6:0] w, int s);
    mk = '0;
    for (int j = 0; j < SPAN; j++) begin
      int t = j - s;
      if (t >= 3 && t < 24) mk[j] = w[6 - (t-3)/3];
    end
  endfunction

  task automatic step(bit en, logic [6:0] cw, logic [LANES*SPAN-1:0] smp, string tag);
    logic [LANES*7-1:0] edat;
    logic [LANES*3-1:0] eph;
    bit tnx, all;
    @(negedge clk);
    deskew_en = en; clk_word = cw; lane_samp = smp;
    tnx = en && (cw == 7'b1111100 || cw == 7'b1100000 ||
                 (m_train && !(cw == 7'b1111000 || cw == 7'b1110000)));
    for (int l = 0; l < LANES; l++) begin
      logic [SPAN-1:0] v = smp[l*SPAN +: SPAN];
      int lo = -1, hi;
      edat[l*7 +: 7] = tnx ? 7'd0 : grab(v, en ? m_ph[l] : 0);
      for (int k = 0; k < 7; k++) if (grab(v, k-3) == EXPW && lo < 0) lo = k;
      hi = lo;
      for (int k = 0; k < 7; k++) if (lo >= 0 && k == hi+1 && grab(v, k-3) == EXPW) hi = k;
      if (!en) begin m_ph[l] = 0; m_lk[l] = 0; end
      else if (tnx && lo >= 0) begin m_ph[l] = (lo+hi)/2 - 3; m_lk[l] = 1; end
      else if (tnx && !m_train) m_lk[l] = 0;
    end
    m_train = tnx;
    all = 1;
    for (int l = 0; l < LANES; l++) begin
      eph[l*3 +: 3] = 3'(m_ph[l]);
      all &= m_lk[l];
    end
    @(posedge clk); #1;
    chk({tag, " phase"}, 64'(phase_o), 64'(eph));
    chk({tag, " data"}, 64'(data_o), 64'(edat));
    chk({tag, " trained"}, 64'(trained_o), 64'(all));
  endtask

  function automatic logic [LANES*SPAN-1:0] pack(logic [6:0] w[LANES], int s[LANES]);
    for (int l = 0; l < LANES; l++) pack[l*SPAN +: SPAN] = mk(w[l], s[l]);
  endfunction

  initial begin
    #(CLK_PER*150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [6:0] tw[LANES], dw[LANES];
    int sk[LANES];
    void'($urandom(32'h5eed));
    for (int l = 0; l < LANES; l++) begin m_ph[l] = 0; m_lk[l] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 phase", 64'(phase_o), 0);
    chk("R1 data", 64'(data_o), 0);
    chk("R1 trained", 64'(trained_o), 0);
    @(negedge clk); rst_n = 1;

    // directed training: skews -3,-1,+2,+3
    sk = '{-3, -1, 2, 3};
    tw = '{EXPW, EXPW, EXPW, EXPW};
    step(1, 7'b1111100, pack(tw, sk), "R2 entry");
    chk("R4 edge phases", 64'(phase_o), 64'(12'b010_010_111_101));
    chk("R2 muted", 64'(data_o), 0);
    chk("R6 trained", 64'(trained_o), 1);
    step(1, 7'b0101010, pack(tw, sk), "R3 other word stays");
    chk("R2 still muted", 64'(data_o), 0);
    dw = '{7'h55, 7'h2a, 7'h7f, 7'h13};
    step(1, 7'b1110000, pack(dw, sk), "R3 exit");
    chk("R8 data via lock", 64'(data_o), 64'({7'h13, 7'h7f, 7'h2a, 7'h55}));

    // retrain: lane 2 misses on the first training word
    sk = '{0, 1, -2, -1};
    tw = '{EXPW, EXPW, 7'h00, EXPW};
    step(1, 7'b1100000, pack(tw, sk), "R6 retrain clear");
    chk("R5 lane2 kept", 64'(phase_o[8:6]), 64'(3'b010));
    chk("R6 not all locked", 64'(trained_o), 0);
    tw = '{EXPW, EXPW, EXPW, EXPW};
    step(1, 7'b1100000, pack(tw, sk), "R4 retrain hit");
    chk("R4 phases", 64'(phase_o), 64'(12'b111_110_001_000));
    step(1, 7'b1111000, pack(dw, sk), "R3 exit2");

    // disable: training word ignored, nominal phase
    step(0, 7'b1111100, pack(tw, sk), "R7 off");
    chk("R7 phase zero", 64'(phase_o), 0);
    chk("R7 trained low", 64'(trained_o), 0);
    step(0, 7'b1111000, pack(dw, sk), "R7 nominal data");

    // random mix
    for (int n = 0; n < 400; n++) begin
      bit en = ($urandom % 10) != 0;
      logic [6:0] cw;
      int r = $urandom % 6;
      cw = (r == 0) ? 7'b1111100 : (r == 1) ? 7'b1100000 : (r == 2) ? 7'b1111000 :
           (r == 3) ? 7'b1110000 : 7'($urandom);
      for (int l = 0; l < LANES; l++) begin
        sk[l] = int'($urandom % 7) - 3;
        tw[l] = (m_train || r < 2) ? ((($urandom % 5) == 0) ? 7'($urandom) : EXPW) : 7'($urandom);
      end
      step(en, cw, pack(tw, sk), "R4 R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule